// File: doc/BRIEF.md
# Multiplexed-Address DRAM Access Controller

This block connects a single-word request port to a small behavioural DRAM store of 4 rows by 4 columns of 8-bit cells. The requester supplies a 4-bit cell address, a write flag and write data. Each request is accepted with a valid/ready handshake. The controller splits the address into a row index and a column index. It sends the two indices one after the other over one narrow shared bus, with a row strobe marking the row phase and a column strobe marking the column phase.

A row strobe copies the whole selected row into a row buffer. Column strobes then read or update one cell of that buffer. The controller records which row is open. A request to that row skips the row phase. A request to another row first writes the buffer back to the store, then opens the new row. Writes change only the buffer, so a row reaches the store when it is closed.

A timer raises a refresh request at a fixed interval. The refresh waits for the access in progress to finish. It then takes precedence over new requests, writes back any open row and leaves no row open. Read data appears with a one-cycle valid pulse, a fixed number of cycles after its column strobe.

Top module: `dram_rd_ctrl`

## Requirements
- R1: After reset, req_ready is 1, no strobe is active, rd_valid is 0 and no row is open, so the first access opens its row.
- R2: A request is taken only in a cycle where req_valid and req_ready are both 1. req_ready is 0 while an access or refresh is in progress or a refresh is pending. A request held while req_ready is 0 has no effect until it is taken.
- R3: The address encodes the row in req_addr[3:2] and the column in req_addr[1:0]. When no row is open, the cycle after acceptance drives row_stb with the row on bus_addr, and the next cycle drives col_stb with the column on bus_addr.
- R4: When the requested row is already open, col_stb with the column on bus_addr comes in the cycle after acceptance, with no row strobe.
- R5: When a different row is open, one cycle with no strobe (row write-back) follows acceptance, then the row strobe, then the column strobe.
- R6: A read raises rd_valid for exactly one cycle, RD_LAT cycles after its column strobe cycle. A write raises no rd_valid.
- R7: Read data equals the value most recently written to that address, or 0 if the address was never written. This holds across row changes and refreshes.
- R8: The refresh request becomes pending every REF_INTERVAL cycles after reset. Once the current access has finished it takes precedence over new requests, and ref_stb is high for one cycle.
- R9: If a row is open when a refresh starts, one write-back cycle comes before ref_stb. After the refresh no row is open, so the next access needs a row strobe.
- R10: At most one of row_stb, col_stb and ref_stb is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 4 | Cell address: row in [3:2], column in [1:0] |
| req_wdata | input | 8 | Write data |
| req_ready | output | 1 | Controller can take a request |
| bus_addr | output | 2 | Shared row/column index bus |
| row_stb | output | 1 | Row phase strobe |
| col_stb | output | 1 | Column phase strobe |
| ref_stb | output | 1 | Refresh strobe |
| rd_valid | output | 1 | Read data valid pulse |
| rd_data | output | 8 | Read data |

## Verification
The bench builds the block with RD_LAT = 3 and REF_INTERVAL = 37. The short refresh period makes refresh requests land during all kinds of accesses: in idle time, during a miss's write-back, and just before a row hit that the refresh turns into a reopen. The three-cycle read latency lets read results arrive while the following request's strobes are already on the bus.

// File: rtl/dram_rd_pkg.sv
package dram_rd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_CLOSE = 3'd1,
        ST_OPEN  = 3'd2,
        ST_COL   = 3'd3,
        ST_REF   = 3'd4
    } ctl_state_e;

endpackage

// File: rtl/dram_ref_timer.sv
module dram_ref_timer #(
    parameter int INTERVAL = 512
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (INTERVAL > 1) ? $clog2(INTERVAL) : 1;

    logic [CW-1:0] cnt_q, cnt_d;

    always_comb begin
        tick  = (cnt_q == CW'(INTERVAL - 1));
        cnt_d = tick ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/dram_cell_array.sv
module dram_cell_array #(
    parameter int ROW_BITS = 2,
    parameter int COL_BITS = 2,
    parameter int DATA_W   = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                open_stb,
    input  logic [ROW_BITS-1:0] open_row,
    input  logic                wb_stb,
    input  logic                col_wr,
    input  logic [COL_BITS-1:0] col_sel,
    input  logic [DATA_W-1:0]   col_wdata,
    output logic [DATA_W-1:0]   col_rdata
);
    localparam int ROWS = 1 << ROW_BITS;
    localparam int COLS = 1 << COL_BITS;

    typedef logic [COLS-1:0][DATA_W-1:0] line_t;

    line_t               rows_w [ROWS];
    line_t               buf_q, buf_d;
    logic [ROW_BITS-1:0] brow_q, brow_d;

    // storage rows: each row takes the buffer back when it is closed
    for (genvar r = 0; r < ROWS; r++) begin : g_row
        line_t line_q;
        logic  wb_hit;
        assign wb_hit = wb_stb && (brow_q == ROW_BITS'(r));
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      line_q <= '0;
            else if (wb_hit) line_q <= buf_q;
        end
        assign rows_w[r] = line_q;
    end

    always_comb begin
        buf_d  = buf_q;
        brow_d = brow_q;
        if (open_stb) begin
            buf_d  = rows_w[open_row];
            brow_d = open_row;
        end
        if (col_wr) buf_d[col_sel] = col_wdata;
        col_rdata = buf_q[col_sel];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            buf_q  <= '0;
            brow_q <= '0;
        end else begin
            buf_q  <= buf_d;
            brow_q <= brow_d;
        end
    end
endmodule

// File: rtl/dram_rd_pipe.sv
module dram_rd_pipe #(
    parameter int DATA_W = 8,
    parameter int LAT    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch,
    input  logic [DATA_W-1:0] din,
    output logic              vld_out,
    output logic [DATA_W-1:0] dout
);
    logic [LAT-1:0]    v_q, v_d;
    logic [DATA_W-1:0] d_q [LAT];
    logic [DATA_W-1:0] d_d [LAT];

    always_comb begin
        v_d[0] = launch;
        d_d[0] = din;
        for (int i = 1; i < LAT; i++) begin
            v_d[i] = v_q[i-1];
            d_d[i] = d_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            v_q <= '0;
            for (int i = 0; i < LAT; i++) d_q[i] <= '0;
        end else begin
            v_q <= v_d;
            for (int i = 0; i < LAT; i++) d_q[i] <= d_d[i];
        end
    end

    assign vld_out = v_q[LAT-1];
    assign dout    = d_q[LAT-1];
endmodule

// File: rtl/dram_rd_ctrl.sv
module dram_rd_ctrl
    import dram_rd_pkg::*;
#(
    parameter int ROW_BITS     = 2,
    parameter int COL_BITS     = 2,
    parameter int DATA_W       = 8,
    parameter int RD_LAT       = 2,
    parameter int REF_INTERVAL = 512,
    localparam int ADDR_W      = ROW_BITS + COL_BITS,
    localparam int BUS_W       = (ROW_BITS > COL_BITS) ? ROW_BITS : COL_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic [BUS_W-1:0]  bus_addr,
    output logic              row_stb,
    output logic              col_stb,
    output logic              ref_stb,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);
    typedef struct packed {
        ctl_state_e          st;
        logic                open_vld;
        logic [ROW_BITS-1:0] open_row;
        logic                pend;
        logic                tgt_ref;
        logic [ROW_BITS-1:0] rq_row;
        logic [COL_BITS-1:0] rq_col;
        logic                rq_we;
        logic [DATA_W-1:0]   rq_wdata;
    } ctl_t;

    ctl_t              c_q, c_d;
    logic              tick;
    logic              wb_stb;
    logic              open_stb;
    logic [DATA_W-1:0] cell_rdata;
    logic [ROW_BITS-1:0] req_row;

    assign req_row = req_addr[ADDR_W-1:COL_BITS];

    always_comb begin
        c_d      = c_q;
        wb_stb   = 1'b0;
        open_stb = 1'b0;
        row_stb  = 1'b0;
        col_stb  = 1'b0;
        ref_stb  = 1'b0;
        bus_addr = '0;
        unique case (c_q.st)
            ST_IDLE: begin
                if (c_q.pend) begin
                    c_d.tgt_ref = 1'b1;
                    c_d.st      = c_q.open_vld ? ST_CLOSE : ST_REF;
                end else if (req_valid) begin
                    c_d.rq_row   = req_row;
                    c_d.rq_col   = req_addr[COL_BITS-1:0];
                    c_d.rq_we    = req_write;
                    c_d.rq_wdata = req_wdata;
                    c_d.tgt_ref  = 1'b0;
                    if (c_q.open_vld && (c_q.open_row == req_row)) c_d.st = ST_COL;
                    else if (c_q.open_vld)                         c_d.st = ST_CLOSE;
                    else                                           c_d.st = ST_OPEN;
                end
            end
            ST_CLOSE: begin
                wb_stb       = 1'b1;
                c_d.open_vld = 1'b0;
                c_d.st       = c_q.tgt_ref ? ST_REF : ST_OPEN;
            end
            ST_OPEN: begin
                row_stb      = 1'b1;
                open_stb     = 1'b1;
                bus_addr     = BUS_W'(c_q.rq_row);
                c_d.open_vld = 1'b1;
                c_d.open_row = c_q.rq_row;
                c_d.st       = ST_COL;
            end
            ST_COL: begin
                col_stb  = 1'b1;
                bus_addr = BUS_W'(c_q.rq_col);
                c_d.st   = ST_IDLE;
            end
            ST_REF: begin
                ref_stb      = 1'b1;
                c_d.open_vld = 1'b0;
                c_d.st       = ST_IDLE;
            end
            default: c_d.st = ST_IDLE;
        endcase
        c_d.pend = (c_q.pend && (c_q.st != ST_REF)) || tick;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign req_ready = (c_q.st == ST_IDLE) && !c_q.pend;

    dram_ref_timer #(
        .INTERVAL (REF_INTERVAL)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    dram_cell_array #(
        .ROW_BITS (ROW_BITS),
        .COL_BITS (COL_BITS),
        .DATA_W   (DATA_W)
    ) u_cells (
        .clk       (clk),
        .rst_n     (rst_n),
        .open_stb  (open_stb),
        .open_row  (c_q.rq_row),
        .wb_stb    (wb_stb),
        .col_wr    (col_stb && c_q.rq_we),
        .col_sel   (c_q.rq_col),
        .col_wdata (c_q.rq_wdata),
        .col_rdata (cell_rdata)
    );

    dram_rd_pipe #(
        .DATA_W (DATA_W),
        .LAT    (RD_LAT)
    ) u_pipe (
        .clk     (clk),
        .rst_n   (rst_n),
        .launch  (col_stb && !c_q.rq_we),
        .din     (cell_rdata),
        .vld_out (rd_valid),
        .dout    (rd_data)
    );
endmodule

// File: rtl/dram_rd_ctrl_chk.sv
module dram_rd_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic req_ready,
    input logic row_stb,
    input logic col_stb,
    input logic ref_stb,
    input logic rd_valid
);
    assert_strobe_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({row_stb, col_stb, ref_stb}));

    assert_ready_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !(row_stb || col_stb || ref_stb));

    assert_row_then_col_R3: assert property (@(posedge clk) disable iff (!rst_n)
        row_stb |=> col_stb);

    assert_valid_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

    assert_ref_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ref_stb |=> !ref_stb && !col_stb);
endmodule

bind dram_rd_ctrl dram_rd_ctrl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .row_stb   (row_stb),
    .col_stb   (col_stb),
    .ref_stb   (ref_stb),
    .rd_valid  (rd_valid)
);

// File: tb/sim_dram_rd_ctrl.sv
module sim_dram_rd_ctrl;
    localparam int LAT  = 3;
    localparam int INTV = 37;
    localparam int N    = 160;
    localparam int EV_CLOSE = 1;
    localparam int EV_ROW   = 2;
    localparam int EV_COL   = 3;
    localparam int EV_REF   = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic       req_write = 1'b0;
    logic [3:0] req_addr = '0;
    logic [7:0] req_wdata = '0;
    logic       req_ready;
    logic [1:0] bus_addr;
    logic       row_stb, col_stb, ref_stb, rd_valid;
    logic [7:0] rd_data;

    always #5 clk = ~clk;

    dram_rd_ctrl #(.RD_LAT(LAT), .REF_INTERVAL(INTV)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
        .bus_addr(bus_addr), .row_stb(row_stb), .col_stb(col_stb),
        .ref_stb(ref_stb), .rd_valid(rd_valid), .rd_data(rd_data)
    );

    int    nchk = 0;
    int    nfail = 0;
    bit    done = 0;
    int    cyc = 0;
    int    it_we [N];
    int    it_addr [N];
    int    it_data [N];
    int    mem [16];
    int    evq [$];
    string evtag [$];
    int    rdue [$];
    int    rdat [$];
    bit    pend = 0;
    bit    mopen = 0;
    bit    ref_closed = 0;
    int    mrow = 0;
    int    m_we = 0, m_addr = 0, m_data = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s cyc=%0d actual=%0d expected=%0d", tag, cyc, act, exp);
        end
    endtask

    task automatic push_ev(input int kind, input int field, input string tag);
        evq.push_back(kind * 8 + field);
        evtag.push_back(tag);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog expired cyc=%0d actual=%0d expected=%0d", cyc, 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
            $finish;
        end
    end

    initial begin
        int it;
        int extra;
        for (int i = 0; i < 16; i++) mem[i] = 0;
        for (int i = 0; i < N; i++) begin
            if (i < 16) begin
                it_we[i] = 1; it_addr[i] = i; it_data[i] = (i * 17 + 3) & 255;
            end else if (i < 32) begin
                it_we[i] = 0; it_addr[i] = ((i % 4) * 4) + ((i - 16) / 4); it_data[i] = 0;
            end else begin
                it_we[i] = (i % 3 == 0) ? 1 : 0;
                it_addr[i] = (i * 7 + i / 5) % 16;
                it_data[i] = (i * 29 + 5) & 255;
            end
        end
        it = 0;
        extra = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        while (extra < LAT + 6) begin
            int h, f, nstb;
            bit exp_rdy, expv, v;
            string tg;
            h = (evq.size() != 0) ? evq[0] / 8 : 0;
            f = (evq.size() != 0) ? evq[0] % 8 : 0;
            tg = (evtag.size() != 0) ? evtag[0] : "R2 idle quiet";
            exp_rdy = (evq.size() == 0) && !pend;
            nstb = int'(row_stb) + int'(col_stb) + int'(ref_stb);
            if (cyc == 0) begin
                // R1: state right after reset
                chk(req_ready == 1'b1, "R1 ready after reset", int'(req_ready), 1);
                chk(nstb == 0, "R1 no strobe after reset", nstb, 0);
                chk(rd_valid == 1'b0, "R1 no data-valid after reset", int'(rd_valid), 0);
            end
            chk(req_ready == exp_rdy, "R2 ready", int'(req_ready), int'(exp_rdy));
            chk(row_stb == (h == EV_ROW), {tg, " row strobe"}, int'(row_stb), int'(h == EV_ROW));
            if (h == EV_ROW) chk(bus_addr == f, {tg, " row index"}, int'(bus_addr), f);
            chk(col_stb == (h == EV_COL), {tg, " column strobe"}, int'(col_stb), int'(h == EV_COL));
            if (h == EV_COL) chk(bus_addr == f, {tg, " column index"}, int'(bus_addr), f);
            chk(ref_stb == (h == EV_REF), "R8 refresh strobe", int'(ref_stb), int'(h == EV_REF));
            chk(nstb <= 1, "R10 strobe exclusive", nstb, 1);
            expv = (rdue.size() != 0) && (rdue[0] == cyc);
            chk(rd_valid == expv, "R6 data-valid timing", int'(rd_valid), int'(expv));
            if (expv) begin
                chk(rd_data == rdat[0], "R7 read data", int'(rd_data), rdat[0]);
                void'(rdue.pop_front());
                void'(rdat.pop_front());
            end

            // drive this cycle's request
            v = (it < N) && ((cyc % 11) != 5);
            req_valid = v;
            if (v) begin
                req_write = it_we[it][0];
                req_addr  = 4'(it_addr[it]);
                req_wdata = 8'(it_data[it]);
            end

            // reference model: what the coming edge does
            if (evq.size() != 0) begin
                void'(evq.pop_front());
                void'(evtag.pop_front());
                case (h)
                    EV_CLOSE: mopen = 0;
                    EV_ROW: begin mopen = 1; mrow = f; ref_closed = 0; end
                    EV_COL: begin
                        if (m_we != 0) mem[m_addr] = m_data;
                        else begin rdue.push_back(cyc + LAT); rdat.push_back(mem[m_addr]); end
                    end
                    EV_REF: begin pend = 0; mopen = 0; ref_closed = 1; end
                    default: ;
                endcase
            end else if (pend) begin
                if (mopen) push_ev(EV_CLOSE, 0, "R9 flush before refresh");
                push_ev(EV_REF, 0, "R8 refresh");
            end else if (v) begin
                int r, c;
                m_we = it_we[it]; m_addr = it_addr[it]; m_data = it_data[it];
                r = m_addr / 4; c = m_addr % 4;
                if (mopen && mrow == r) begin
                    push_ev(EV_COL, c, "R4 hit");
                end else if (mopen) begin
                    push_ev(EV_CLOSE, 0, "R5 miss");
                    push_ev(EV_ROW, r, "R5 miss");
                    push_ev(EV_COL, c, "R5 miss");
                end else begin
                    string t;
                    t = ref_closed ? "R9 reopen after refresh" : "R3 closed row";
                    push_ev(EV_ROW, r, t);
                    push_ev(EV_COL, c, t);
                end
                it++;
            end
            if ((cyc % INTV) == INTV - 1) pend = 1;

            if (it >= N && evq.size() == 0 && rdue.size() == 0) extra++;
            cyc++;
            @(negedge clk);
        end
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end
endmodule